// File: doc/BRIEF.md
# Amplifier Control Register Bank over I2C

This block is an I2C target that holds the control settings of a two-channel audio amplifier and presents them as parallel outputs to the rest of the chip. It oversamples SCL and SDA on the system clock and finds start, repeated start and stop conditions. It answers one fixed 7-bit bus address and pulls SDA low through an open-drain enable to acknowledge or to send read data.

A write carries the register index and then one data byte. A read first sets the register index with a short write, then uses a repeated start with the read bit, and the addressed byte is shifted out MSB first. A status register reports the index of the most recent register access. A write of FFh to index FFh returns every register to its power-up value.

Top module: `amp_ctl_i2c`

## Requirements
- R1: The block answers only bus address 1101100b (write byte D8h, read byte D9h); any other address gets no acknowledge, leaves SDA released for the rest of that transfer and changes no output.
- R2: After reset the outputs are: format 000, rate 01, clock ratio 00, both gains 0, both mutes 0, both disables 0, muted-pulse enable 1, modulation index 0, shaper order 0; SDA is released.
- R3: A write to index 10h sets format from bits [2:0], rate from [4:3] and clock ratio from [6:5]; a write to 20h (left) or 21h (right) sets gain from [5:0], mute from bit 6 and disable from bit 7; a write to 30h sets muted-pulse enable from bit 1, modulation index from bit 2 and shaper order from bit 3.
- R4: Reading 10h returns bit 7 as 0; reading 30h returns bit 0 as 1 and bits [7:4] as 0; other readable bits return the value last written.
- R5: For a matching address the block acknowledges the address byte, the index byte and the data byte of a write, including writes to unmapped indices, to 00h and to FFh.
- R6: Reading index 00h returns the index of the most recent register access (write data byte or read), taken before the current read updates it; writes to 00h change no control output.
- R7: Writing FFh to index FFh restores every register, the status register included, to its reset value; any other value written to FFh has no effect.
- R8: Reads of unmapped indices return 00h, and writes to them change no output.
- R9: After the read byte the block releases SDA, ignores the controller's acknowledge bit, and accepts a new transaction after the stop.
- R10: SDA is only pulled low starting while SCL is low, and is released by a stop condition.
- R11: The index does not advance: a second read started with only the read address returns the same register again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line (asynchronous) |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| fmt_o | output | 3 | Serial input format |
| rate_o | output | 2 | Sample-rate selection |
| mclk_div_o | output | 2 | Master clock ratio |
| gain_l_o | output | 6 | Left gain |
| mute_l_o | output | 1 | Left mute control |
| off_l_o | output | 1 | Left output disable |
| gain_r_o | output | 6 | Right gain |
| mute_r_o | output | 1 | Right mute control |
| off_r_o | output | 1 | Right output disable |
| mute_pulse_o | output | 1 | Pulse operation while muted |
| mod_index_o | output | 1 | Modulation index select |
| ns_order_o | output | 1 | Noise shaper order select |

## Verification
The bench targets the fixed bits and reserved bits on readback, where a design storing whole bytes would return a 1 in format bit 7 or lose the forced 1 in bit 0 of the control register. It reads the status register after reads, unmapped writes and a write to the reset index, so a design that latched the index byte too early or the data byte instead of the index would show the wrong value. It writes a non-FFh value to FFh and then FFh itself, catching a reset that fires on any write, and it reads twice without a new index, catching an index that advances. A foreign address is sent for both write and read to catch a design that acknowledges every address.

// File: rtl/amp_ctl_pkg.sv
package amp_ctl_pkg;
  localparam int unsigned DW  = 8;
  localparam int unsigned NCH = 2;

  localparam logic [6:0]    DEV_ADDR = 7'b1101100;
  localparam logic [DW-1:0] IX_STAT  = 8'h00;
  localparam logic [DW-1:0] IX_FMT   = 8'h10;
  localparam logic [DW-1:0] IX_GAIN  = 8'h20;
  localparam logic [DW-1:0] IX_MISC  = 8'h30;
  localparam logic [DW-1:0] IX_CLR   = 8'hFF;
  localparam logic [DW-1:0] CLR_KEY  = 8'hFF;

  localparam logic [6:0] FMT_RST  = 7'h08;
  localparam logic [2:0] MISC_RST = 3'b001;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_SKIP
  } bus_st_e;
endpackage

// File: rtl/amp_ctl_sync.sv
module amp_ctl_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= '1;
      else if (s == 0) pipe_q[s] <= d_i;
      else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/amp_ctl_bus.sv
module amp_ctl_bus
  import amp_ctl_pkg::*;
#(
  parameter logic [6:0] ADDR7 = DEV_ADDR
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_s_i,
  input  logic          sda_s_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          sda_oe_o,
  output logic [DW-1:0] ix_o,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_data_o,
  output logic          rd_en_o
);
  localparam int unsigned CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  bus_st_e       st_q;
  logic          scl_d, sda_d;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q, tx_q, ix_q;
  logic          rw_q, have_ix_q, done_q, oe_q;

  logic start_det, stop_det, scl_rise, scl_fall;
  assign start_det = scl_s_i & scl_d & sda_d & ~sda_s_i;
  assign stop_det  = scl_s_i & scl_d & ~sda_d & sda_s_i;
  assign scl_rise  = scl_s_i & ~scl_d;
  assign scl_fall  = ~scl_s_i & scl_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
      cnt_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      ix_q      <= '0;
      rw_q      <= 1'b0;
      have_ix_q <= 1'b0;
      done_q    <= 1'b0;
      oe_q      <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
      rd_en_o   <= 1'b0;
    end else begin
      scl_d   <= scl_s_i;
      sda_d   <= sda_s_i;
      wr_en_o <= 1'b0;
      rd_en_o <= 1'b0;
      if (start_det) begin
        st_q      <= ST_ADDR;
        cnt_q     <= '0;
        oe_q      <= 1'b0;
        have_ix_q <= 1'b0;
        done_q    <= 1'b0;
      end else if (stop_det) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[DW-2:0], sda_s_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == LAST) begin
              cnt_q <= '0;
              if (sh_q[DW-1:1] == ADDR7) begin
                st_q <= ST_ADDR_ACK;
                oe_q <= 1'b1;
                rw_q <= sh_q[0];
              end else begin
                st_q <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                st_q    <= ST_RD;
                tx_q    <= rd_data_i;
                oe_q    <= ~rd_data_i[DW-1];
                rd_en_o <= 1'b1;
              end else begin
                st_q <= ST_WR;
                oe_q <= 1'b0;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[DW-2:0], sda_s_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == LAST) begin
              st_q  <= ST_WR_ACK;
              oe_q  <= 1'b1;
              cnt_q <= '0;
              if (!have_ix_q) begin
                ix_q      <= sh_q;
                have_ix_q <= 1'b1;
              end else begin
                wr_en_o   <= 1'b1;
                wr_data_o <= sh_q;
                done_q    <= 1'b1;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              oe_q <= 1'b0;
              st_q <= done_q ? ST_SKIP : ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == LAST) begin
                st_q <= ST_RD_ACK;
                oe_q <= 1'b0;
              end else begin
                oe_q <= ~tx_q[DW-2];
                tx_q <= tx_q << 1;
              end
            end
          end
          ST_RD_ACK: if (scl_rise) st_q <= ST_SKIP;
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign ix_o     = ix_q;
endmodule

// File: rtl/amp_ctl_regs.sv
module amp_ctl_regs
  import amp_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DW-1:0]     ix_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              rd_en_i,
  output logic [DW-1:0]     rd_data_o,
  output logic [6:0]        fmt_o,
  output logic [NCH*DW-1:0] gain_o,
  output logic [2:0]        misc_o
);
  logic clr;
  assign clr = wr_en_i && ix_i == IX_CLR && wr_data_i == CLR_KEY;

  logic [6:0]    fmt_q;
  logic [2:0]    misc_q;
  logic [DW-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q  <= FMT_RST;
      misc_q <= MISC_RST;
      stat_q <= '0;
    end else if (clr) begin
      fmt_q  <= FMT_RST;
      misc_q <= MISC_RST;
      stat_q <= '0;
    end else begin
      if (wr_en_i && ix_i == IX_FMT)  fmt_q  <= wr_data_i[6:0];
      if (wr_en_i && ix_i == IX_MISC) misc_q <= wr_data_i[3:1];
      if (wr_en_i || rd_en_i)         stat_q <= ix_i;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [DW-1:0] IX = DW'(IX_GAIN + c);
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (clr) q <= '0;
      else if (wr_en_i && ix_i == IX) q <= wr_data_i;
    end
    assign gain_o[c*DW +: DW] = q;
  end

  always_comb begin
    rd_data_o = '0;
    unique case (ix_i)
      IX_STAT: rd_data_o = stat_q;
      IX_FMT:  rd_data_o = {1'b0, fmt_q};
      IX_MISC: rd_data_o = {4'b0000, misc_q, 1'b1};
      default: ;
    endcase
    for (int c = 0; c < NCH; c++)
      if (ix_i == DW'(IX_GAIN + c)) rd_data_o = gain_o[c*DW +: DW];
  end

  assign fmt_o  = fmt_q;
  assign misc_o = misc_q;
endmodule

// File: rtl/amp_ctl_i2c.sv
module amp_ctl_i2c
  import amp_ctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic [2:0] fmt_o,
  output logic [1:0] rate_o,
  output logic [1:0] mclk_div_o,
  output logic [5:0] gain_l_o,
  output logic       mute_l_o,
  output logic       off_l_o,
  output logic [5:0] gain_r_o,
  output logic       mute_r_o,
  output logic       off_r_o,
  output logic       mute_pulse_o,
  output logic       mod_index_o,
  output logic       ns_order_o
);
  logic [1:0]        bus_s;
  logic              scl_s, sda_s;
  logic [DW-1:0]     acc_ix, wr_data, rd_data;
  logic              wr_en, rd_en;
  logic [6:0]        fmt;
  logic [NCH*DW-1:0] gain;
  logic [2:0]        misc;

  amp_ctl_sync #(.W(2), .STAGES(2)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i ({scl_i, sda_i}), .q_o (bus_s)
  );
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  amp_ctl_bus u_bus (
    .clk_i (clk_i), .rst_ni (rst_ni), .scl_s_i (scl_s), .sda_s_i (sda_s),
    .rd_data_i (rd_data), .sda_oe_o (sda_oe_o), .ix_o (acc_ix),
    .wr_en_o (wr_en), .wr_data_o (wr_data), .rd_en_o (rd_en)
  );

  amp_ctl_regs u_regs (
    .clk_i (clk_i), .rst_ni (rst_ni), .ix_i (acc_ix), .wr_en_i (wr_en),
    .wr_data_i (wr_data), .rd_en_i (rd_en), .rd_data_o (rd_data),
    .fmt_o (fmt), .gain_o (gain), .misc_o (misc)
  );

  assign fmt_o        = fmt[2:0];
  assign rate_o       = fmt[4:3];
  assign mclk_div_o   = fmt[6:5];
  assign gain_l_o     = gain[5:0];
  assign mute_l_o     = gain[6];
  assign off_l_o      = gain[7];
  assign gain_r_o     = gain[DW+5:DW];
  assign mute_r_o     = gain[DW+6];
  assign off_r_o      = gain[DW+7];
  assign mute_pulse_o = misc[0];
  assign mod_index_o  = misc[1];
  assign ns_order_o   = misc[2];
endmodule

// File: rtl/amp_ctl_i2c_chk.sv
module amp_ctl_i2c_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_s,
  input logic        sda_s,
  input logic        oe,
  input logic        wr_en,
  input logic [7:0]  ix,
  input logic [7:0]  rd_data,
  input logic [25:0] cfg
);
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe) |-> !$past(scl_s)); // R10

  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s) && sda_s && !$past(sda_s)) |=> !oe); // R9

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(cfg)); // R8

  AST_FMT_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ix == 8'h10) |-> !rd_data[7]); // R4

  AST_MISC_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ix == 8'h30) |-> (rd_data[0] && rd_data[7:4] == 4'h0)); // R4

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ix inside {8'h00, 8'h10, 8'h20, 8'h21, 8'h30}) |-> rd_data == 8'h00); // R8
endmodule

bind amp_ctl_i2c amp_ctl_i2c_chk u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .scl_s (scl_s), .sda_s (sda_s),
  .oe (sda_oe_o), .wr_en (wr_en), .ix (acc_ix), .rd_data (rd_data),
  .cfg ({fmt_o, rate_o, mclk_div_o, gain_l_o, mute_l_o, off_l_o,
         gain_r_o, mute_r_o, off_r_o, mute_pulse_o, mod_index_o, ns_order_o})
);

// File: tb/amp_ctl_i2c_tb_top.sv
module amp_ctl_i2c_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe, sda_bus;
  logic [2:0] fmt;
  logic [1:0] rate, mclk_div;
  logic [5:0] gain_l, gain_r;
  logic mute_l, off_l, mute_r, off_r, mute_pulse, mod_index, ns_order;

  always #2 clk = ~clk;
  assign sda_bus = !(m_low || sda_oe);

  amp_ctl_i2c dut_i (
    .clk_i (clk), .rst_ni (rst_n), .scl_i (scl), .sda_i (sda_bus),
    .sda_oe_o (sda_oe), .fmt_o (fmt), .rate_o (rate), .mclk_div_o (mclk_div),
    .gain_l_o (gain_l), .mute_l_o (mute_l), .off_l_o (off_l),
    .gain_r_o (gain_r), .mute_r_o (mute_r), .off_r_o (off_r),
    .mute_pulse_o (mute_pulse), .mod_index_o (mod_index), .ns_order_o (ns_order)
  );

  int n_cmp = 0, n_bad = 0;
  string exp_tag[$];
  int    exp_val[$];

  task automatic expect_item(input string t, input int v);
    exp_tag.push_back(t);
    exp_val.push_back(v);
  endtask

  task automatic observe(input int act);
    string t;
    int    v;
    t = exp_tag.pop_front();
    v = exp_val.pop_front();
    n_cmp++;
    if (act !== v) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", t, act, v);
    end
  endtask

  task automatic wq();
    repeat (10) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    m_low = !b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic start_c();
    m_low = 1'b0; wq(); scl = 1'b1; wq(); m_low = 1'b1; wq(); scl = 1'b0; wq();
  endtask

  task automatic stop_c();
    m_low = 1'b1; wq(); scl = 1'b1; wq(); m_low = 1'b0; wq(); wq();
  endtask

  task automatic byte_out(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    m_low = 1'b0; wq(); scl = 1'b1; wq(); ack = !sda_bus; wq(); scl = 1'b0; wq();
  endtask

  task automatic byte_in(output logic [7:0] d);
    m_low = 1'b0;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      wq(); scl = 1'b1; wq(); d = {d[6:0], sda_bus}; wq(); scl = 1'b0; wq();
    end
    bit_out(1'b1); // no acknowledge
  endtask

  function automatic int cfg_of(input logic [7:0] f, l, r, m);
    return int'({f[2:0], f[4:3], f[6:5], l[5:0], l[6], l[7],
                 r[5:0], r[6], r[7], m[1], m[2], m[3]});
  endfunction

  function automatic int cfg_now();
    return int'({fmt, rate, mclk_div, gain_l, mute_l, off_l,
                 gain_r, mute_r, off_r, mute_pulse, mod_index, ns_order});
  endfunction

  task automatic wr_reg(input logic [7:0] ix, input logic [7:0] d, input string t);
    logic k;
    expect_item({t, " ack addr"}, 1);
    expect_item({t, " ack index"}, 1);
    expect_item({t, " ack data"}, 1);
    start_c();
    byte_out(8'hD8, k); observe(int'(k));
    byte_out(ix, k);    observe(int'(k));
    byte_out(d, k);     observe(int'(k));
    stop_c();
  endtask

  task automatic rd_reg(input logic [7:0] ix, input logic [7:0] ev, input string t);
    logic k;
    logic [7:0] d;
    expect_item({t, " ack addr"}, 1);
    expect_item({t, " ack index"}, 1);
    expect_item({t, " ack read addr"}, 1);
    expect_item({t, " data"}, int'(ev));
    expect_item({t, " R9 sda released"}, 0);
    start_c();
    byte_out(8'hD8, k); observe(int'(k));
    byte_out(ix, k);    observe(int'(k));
    start_c();
    byte_out(8'hD9, k); observe(int'(k));
    byte_in(d);         observe(int'(d));
    stop_c();
    observe(int'(sda_oe));
  endtask

  task automatic rd_again(input logic [7:0] ev, input string t);
    logic k;
    logic [7:0] d;
    expect_item({t, " ack read addr"}, 1);
    expect_item({t, " data"}, int'(ev));
    start_c();
    byte_out(8'hD9, k); observe(int'(k));
    byte_in(d);         observe(int'(d));
    stop_c();
  endtask

  task automatic chk_cfg(input int ev, input string t);
    expect_item(t, ev);
    observe(cfg_now());
  endtask

  int rst_cfg;
  bit finished = 1'b0;

  initial begin
    logic k;
    logic [7:0] d;
    rst_cfg = cfg_of(8'h08, 8'h00, 8'h00, 8'h03);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wq();
    chk_cfg(rst_cfg, "R2 reset outputs");
    expect_item("R2 R10 sda released at reset", 0);
    observe(int'(sda_oe));

    wr_reg(8'h20, 8'hA5, "R5 wr left gain");
    chk_cfg(cfg_of(8'h08, 8'hA5, 8'h00, 8'h03), "R3 left gain fields");
    wr_reg(8'h21, 8'h3C, "R5 wr right gain");
    chk_cfg(cfg_of(8'h08, 8'hA5, 8'h3C, 8'h03), "R3 right gain fields");
    wr_reg(8'h10, 8'hFF, "R5 wr format");
    chk_cfg(cfg_of(8'hFF, 8'hA5, 8'h3C, 8'h03), "R3 format fields");
    wr_reg(8'h30, 8'h0C, "R5 wr misc");
    chk_cfg(cfg_of(8'hFF, 8'hA5, 8'h3C, 8'h0C), "R3 misc fields");

    rd_reg(8'h30, 8'h0D, "R4 rd misc fixed bit");
    wr_reg(8'h30, 8'hFF, "R5 wr misc all ones");
    rd_reg(8'h30, 8'h0F, "R4 rd misc reserved zero");
    rd_reg(8'h10, 8'h7F, "R4 rd format top bit zero");
    rd_reg(8'h21, 8'h3C, "R11 rd right gain");
    rd_again(8'h3C, "R11 repeat read no advance");
    chk_cfg(cfg_of(8'hFF, 8'hA5, 8'h3C, 8'hFF), "R3 state before foreign");

    expect_item("R1 foreign write no ack", 0);
    start_c(); byte_out(8'h6C, k); observe(int'(k));
    byte_out(8'h20, k); byte_out(8'h00, k); stop_c();
    chk_cfg(cfg_of(8'hFF, 8'hA5, 8'h3C, 8'hFF), "R1 foreign write no effect");
    expect_item("R1 foreign read no ack", 0);
    expect_item("R1 foreign read bus idle", 8'hFF);
    start_c(); byte_out(8'h6D, k); observe(int'(k));
    byte_in(d); observe(int'(d)); stop_c();

    rd_reg(8'h00, 8'h21, "R6 status after read");
    wr_reg(8'h40, 8'h12, "R5 R8 wr unmapped");
    chk_cfg(cfg_of(8'hFF, 8'hA5, 8'h3C, 8'hFF), "R8 unmapped write no effect");
    rd_reg(8'h40, 8'h00, "R8 rd unmapped");
    rd_reg(8'h00, 8'h40, "R6 status after unmapped");
    wr_reg(8'h00, 8'h55, "R5 R6 wr status");
    chk_cfg(cfg_of(8'hFF, 8'hA5, 8'h3C, 8'hFF), "R6 status write no effect");
    rd_reg(8'h00, 8'h00, "R6 status holds index not data");

    wr_reg(8'hFF, 8'h12, "R5 R7 wr clear wrong key");
    chk_cfg(cfg_of(8'hFF, 8'hA5, 8'h3C, 8'hFF), "R7 wrong key no effect");
    rd_reg(8'h00, 8'hFF, "R6 R7 status after clear index");
    wr_reg(8'hFF, 8'hFF, "R5 R7 wr clear key");
    chk_cfg(rst_cfg, "R7 clear restores outputs");
    rd_reg(8'h00, 8'h00, "R7 status cleared");
    rd_reg(8'h20, 8'h00, "R7 left gain cleared");
    rd_reg(8'h10, 8'h08, "R7 format cleared");

    finished = 1'b1;
  end

  initial begin
    for (int c = 0; c < 200000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule